// File: doc/BRIEF.md
# Serial-CPU Opcode Group Decoder

This block sits behind the instruction register of a small bit-serial 8-bit processor and turns the opcode byte into the control strobes the rest of the machine needs. The two top bits of the opcode choose one of four instruction groups. The middle three bits name a destination register, and the low three bits name a source register or a sub-operation. From these fields the decoder raises exactly one class strobe: load, ALU, branch, shift or I/O. It also marks operands that refer to memory and presents the condition fields that a later branch-resolution stage tests.

Three byte values stop the processor: 0x00, 0x01 and 0xFF. The value 0xFF would otherwise read as a register move with memory on both sides, so halt detection overrides the group decode. When halt is asserted, no class strobe is raised.

A sequencer pulses the load input together with the opcode byte. The decoded word is registered on that clock edge and held until the next pulse. A sequencer outside this block decides when each part of the instruction executes.

Top module: `serial_op_decoder`

## Requirements
- R1: After reset, and until the first cycle with `ir_load` high, every output is 0.
- R2: When `ir_load` is high at a rising clock edge, all outputs reflect `ir_byte` from that edge on and `dec_valid` is 1. While `ir_load` is low, every output holds its value whatever `ir_byte` does.
- R3: For any loaded opcode o, `dec_group` = o[7:6], `dec_dst` = o[5:3] and `dec_src` = o[2:0]. Register codes are 0=A, 1=B, 2=C, 3=D, 4=E, 5=H, 6=L, 7=memory.
- R4: `dec_halt` is 1 for opcodes 0x00, 0x01 and 0xFF only. A halt opcode raises no class strobe, no memory flag and no branch field.
- R5: Every loaded opcode other than the three halt codes raises exactly one of `cls_load`, `cls_alu`, `cls_branch`, `cls_shift`, `cls_io`.
- R6: Group 2'b11 (register/memory move) raises `cls_load`.
- R7: Group 2'b10 (ALU operation with a register) raises `cls_alu`.
- R8: In group 2'b01, an even o[2:0] raises `cls_branch` with `br_kind` jump (0) when o[1]=0 and call (1) when o[1]=1. An odd o[2:0] raises `cls_io`.
- R9: In group 2'b00, o[2:0] selects the class as follows:
  - 0, 1 and 4 (increment, decrement, ALU immediate) raise `cls_alu`.
  - 2 raises `cls_shift`.
  - 3 and 7 raise `cls_branch` with `br_kind` return (2).
  - 5 raises `cls_branch` with `br_kind` restart (3).
  - 6 (load immediate) raises `cls_load`.
- R10: For a branch, `br_flag_sel` = o[4:3], `br_on_true` = o[5] and `br_always` = o[2]. For every non-branch opcode, `br_kind`, `br_flag_sel`, `br_on_true` and `br_always` are 0.
- R11: `mem_src` is 1 when the group is 2'b11 or 2'b10 and o[2:0]=7. `mem_dst` is 1 when the group is 2'b11 and o[5:3]=7, or when the group is 2'b00, o[2:0]=6 and o[5:3]=7. Both are 0 otherwise, including for halt codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_load | input | 1 | Capture strobe for the opcode byte |
| ir_byte | input | 8 | Opcode byte |
| dec_valid | output | 1 | A decoded opcode is held |
| dec_group | output | 2 | Group field o[7:6] |
| dec_dst | output | 3 | Destination field o[5:3] |
| dec_src | output | 3 | Source field o[2:0] |
| dec_halt | output | 1 | Halt opcode |
| cls_load | output | 1 | Load class strobe |
| cls_alu | output | 1 | ALU class strobe |
| cls_branch | output | 1 | Branch class strobe |
| cls_shift | output | 1 | Shift class strobe |
| cls_io | output | 1 | I/O class strobe |
| mem_src | output | 1 | Source operand is memory |
| mem_dst | output | 1 | Destination operand is memory |
| br_kind | output | 2 | 0 jump, 1 call, 2 return, 3 restart |
| br_flag_sel | output | 2 | Flag selected for the branch test |
| br_on_true | output | 1 | Branch when the selected flag is set |
| br_always | output | 1 | Unconditional branch |

## Verification
The main pattern loads all 256 opcodes back to back. Every byte is compared against a reference decode, so each group boundary and each sub-operation code within group 2'b00 is exercised. Separate loads of 0xFF, 0xFE, 0x00, 0x01 and 0x02 distinguish a correct halt override from a group decode that lets 0xFF through as a memory-to-memory move or that halts on neighbouring codes. A load followed by idle cycles, during which the byte input changes to a halt code, separates a design that holds its decode from one that follows the input without the strobe. Idle cycles right after reset show whether anything leaks out before the first load.

// File: rtl/serial_op_pkg.sv
package serial_op_pkg;
    localparam int OP_W    = 8;
    localparam int GRP_W   = 2;
    localparam int REG_W   = 3;
    localparam int N_GRP   = 1 << GRP_W;
    localparam int N_CLASS = 5;
    localparam int N_HALT  = 3;

    localparam logic [REG_W-1:0] REG_MEM = 3'd7;

    localparam int CL_LOAD   = 0;
    localparam int CL_ALU    = 1;
    localparam int CL_BRANCH = 2;
    localparam int CL_SHIFT  = 3;
    localparam int CL_IO     = 4;

    localparam logic [GRP_W-1:0] GRP_MISC = 2'b00;
    localparam logic [GRP_W-1:0] GRP_FLOW = 2'b01;
    localparam logic [GRP_W-1:0] GRP_ARIT = 2'b10;
    localparam logic [GRP_W-1:0] GRP_MOVE = 2'b11;

    typedef enum logic [1:0] {
        BR_JUMP    = 2'd0,
        BR_CALL    = 2'd1,
        BR_RETURN  = 2'd2,
        BR_RESTART = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic                valid;
        logic [GRP_W-1:0]    group;
        logic [REG_W-1:0]    dst;
        logic [REG_W-1:0]    src;
        logic                halt;
        logic [N_CLASS-1:0]  cls;
        logic                mem_src;
        logic                mem_dst;
        br_kind_e            kind;
        logic [1:0]          flag_sel;
        logic                on_true;
        logic                always_br;
    } dec_word_t;
endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
    import serial_op_pkg::*;
#(
    parameter int                         HALT_CNT  = N_HALT,
    parameter logic [HALT_CNT*OP_W-1:0]   HALT_LIST = {8'hFF, 8'h01, 8'h00}
) (
    input  logic [OP_W-1:0]  op_i,
    output logic [GRP_W-1:0] grp_o,
    output logic [REG_W-1:0] dst_o,
    output logic [REG_W-1:0] src_o,
    output logic             halt_o
);
    localparam int SRC_LO = 0;
    localparam int DST_LO = SRC_LO + REG_W;
    localparam int GRP_LO = DST_LO + REG_W;

    logic [HALT_CNT-1:0] hit;

    assign src_o = op_i[SRC_LO +: REG_W];
    assign dst_o = op_i[DST_LO +: REG_W];
    assign grp_o = op_i[GRP_LO +: GRP_W];

    for (genvar h = 0; h < HALT_CNT; h++) begin : g_halt
        assign hit[h] = (op_i == HALT_LIST[h*OP_W +: OP_W]);
    end

    assign halt_o = |hit;
endmodule

// File: rtl/opdec_class.sv
module opdec_class
    import serial_op_pkg::*;
(
    input  logic [GRP_W-1:0]   grp_i,
    input  logic [REG_W-1:0]   dst_i,
    input  logic [REG_W-1:0]   src_i,
    input  logic               halt_i,
    output logic [N_CLASS-1:0] cls_o,
    output br_kind_e           kind_o,
    output logic               mem_src_o,
    output logic               mem_dst_o
);
    logic [N_GRP-1:0] grp_hit;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_hit[g] = (grp_i == GRP_W'(g));
    end

    always_comb begin
        cls_o     = '0;
        kind_o    = BR_JUMP;
        mem_src_o = 1'b0;
        mem_dst_o = 1'b0;
        if (!halt_i) begin
            if (grp_hit[GRP_MOVE]) begin
                cls_o[CL_LOAD] = 1'b1;
                mem_src_o      = (src_i == REG_MEM);
                mem_dst_o      = (dst_i == REG_MEM);
            end else if (grp_hit[GRP_ARIT]) begin
                cls_o[CL_ALU]  = 1'b1;
                mem_src_o      = (src_i == REG_MEM);
            end else if (grp_hit[GRP_FLOW]) begin
                if (src_i[0]) begin
                    cls_o[CL_IO] = 1'b1;
                end else begin
                    cls_o[CL_BRANCH] = 1'b1;
                    kind_o = src_i[1] ? BR_CALL : BR_JUMP;
                end
            end else begin
                unique case (src_i)
                    3'd0, 3'd1, 3'd4: cls_o[CL_ALU]   = 1'b1;
                    3'd2:             cls_o[CL_SHIFT] = 1'b1;
                    3'd3, 3'd7: begin
                        cls_o[CL_BRANCH] = 1'b1;
                        kind_o           = BR_RETURN;
                    end
                    3'd5: begin
                        cls_o[CL_BRANCH] = 1'b1;
                        kind_o           = BR_RESTART;
                    end
                    default: begin
                        cls_o[CL_LOAD] = 1'b1;
                        mem_dst_o      = (dst_i == REG_MEM);
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/opdec_branch.sv
module opdec_branch (
    input  logic       is_branch_i,
    input  logic [3:0] cond_bits_i,
    output logic [1:0] flag_sel_o,
    output logic       on_true_o,
    output logic       always_o
);
    always_comb begin
        flag_sel_o = 2'b00;
        on_true_o  = 1'b0;
        always_o   = 1'b0;
        if (is_branch_i) begin
            always_o   = cond_bits_i[0];
            flag_sel_o = cond_bits_i[2:1];
            on_true_o  = cond_bits_i[3];
        end
    end
endmodule

// File: rtl/serial_op_decoder.sv
module serial_op_decoder
    import serial_op_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_load,
    input  logic [OP_W-1:0]  ir_byte,
    output logic             dec_valid,
    output logic [GRP_W-1:0] dec_group,
    output logic [REG_W-1:0] dec_dst,
    output logic [REG_W-1:0] dec_src,
    output logic             dec_halt,
    output logic             cls_load,
    output logic             cls_alu,
    output logic             cls_branch,
    output logic             cls_shift,
    output logic             cls_io,
    output logic             mem_src,
    output logic             mem_dst,
    output logic [1:0]       br_kind,
    output logic [1:0]       br_flag_sel,
    output logic             br_on_true,
    output logic             br_always
);
    logic [GRP_W-1:0]   f_grp;
    logic [REG_W-1:0]   f_dst;
    logic [REG_W-1:0]   f_src;
    logic               f_halt;
    logic [N_CLASS-1:0] c_cls;
    br_kind_e           c_kind;
    logic               c_msrc;
    logic               c_mdst;
    logic [1:0]         b_sel;
    logic               b_true;
    logic               b_always;

    dec_word_t dec_d, dec_q;

    opdec_fields u_fields (
        .op_i   (ir_byte),
        .grp_o  (f_grp),
        .dst_o  (f_dst),
        .src_o  (f_src),
        .halt_o (f_halt)
    );

    opdec_class u_class (
        .grp_i     (f_grp),
        .dst_i     (f_dst),
        .src_i     (f_src),
        .halt_i    (f_halt),
        .cls_o     (c_cls),
        .kind_o    (c_kind),
        .mem_src_o (c_msrc),
        .mem_dst_o (c_mdst)
    );

    opdec_branch u_branch (
        .is_branch_i (c_cls[CL_BRANCH]),
        .cond_bits_i (ir_byte[5:2]),
        .flag_sel_o  (b_sel),
        .on_true_o   (b_true),
        .always_o    (b_always)
    );

    always_comb begin
        dec_d = dec_q;
        if (ir_load) begin
            dec_d.valid     = 1'b1;
            dec_d.group     = f_grp;
            dec_d.dst       = f_dst;
            dec_d.src       = f_src;
            dec_d.halt      = f_halt;
            dec_d.cls       = c_cls;
            dec_d.mem_src   = c_msrc;
            dec_d.mem_dst   = c_mdst;
            dec_d.kind      = c_kind;
            dec_d.flag_sel  = b_sel;
            dec_d.on_true   = b_true;
            dec_d.always_br = b_always;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign dec_valid   = dec_q.valid;
    assign dec_group   = dec_q.group;
    assign dec_dst     = dec_q.dst;
    assign dec_src     = dec_q.src;
    assign dec_halt    = dec_q.halt;
    assign cls_load    = dec_q.cls[CL_LOAD];
    assign cls_alu     = dec_q.cls[CL_ALU];
    assign cls_branch  = dec_q.cls[CL_BRANCH];
    assign cls_shift   = dec_q.cls[CL_SHIFT];
    assign cls_io      = dec_q.cls[CL_IO];
    assign mem_src     = dec_q.mem_src;
    assign mem_dst     = dec_q.mem_dst;
    assign br_kind     = dec_q.kind;
    assign br_flag_sel = dec_q.flag_sel;
    assign br_on_true  = dec_q.on_true;
    assign br_always   = dec_q.always_br;

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (dec_q == '0));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(dec_q));

    p_load_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> dec_valid);

    p_halt_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_halt |-> ({dec_group, dec_dst, dec_src} inside {8'h00, 8'h01, 8'hFF}));

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_halt |-> ({cls_load, cls_alu, cls_branch, cls_shift, cls_io, mem_src, mem_dst} == '0));

    p_ff_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_group == GRP_MOVE && dec_dst == REG_MEM && dec_src == REG_MEM) |-> dec_halt);

    p_one_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_halt) |->
        ($countones({cls_load, cls_alu, cls_branch, cls_shift, cls_io}) == 1));

    p_move_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_halt && dec_group == GRP_MOVE) |-> cls_load);

    p_arit_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_group == GRP_ARIT) |-> cls_alu);

    p_br_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_branch |-> ({br_kind, br_flag_sel, br_on_true, br_always} == '0));
endmodule

// File: tb/serial_op_decoder_bench.sv
module serial_op_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_load = 1'b0;
    logic [7:0] ir_byte = 8'h00;

    logic       dec_valid, dec_halt;
    logic [1:0] dec_group;
    logic [2:0] dec_dst, dec_src;
    logic       cls_load, cls_alu, cls_branch, cls_shift, cls_io;
    logic       mem_src, mem_dst;
    logic [1:0] br_kind, br_flag_sel;
    logic       br_on_true, br_always;

    int compared = 0;
    int mismatched = 0;

    logic [7:0]  q_op[$];
    logic [22:0] q_exp[$];

    always #4 clk = ~clk;

    serial_op_decoder u_serial_op_decoder (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_byte(ir_byte),
        .dec_valid(dec_valid), .dec_group(dec_group), .dec_dst(dec_dst),
        .dec_src(dec_src), .dec_halt(dec_halt), .cls_load(cls_load),
        .cls_alu(cls_alu), .cls_branch(cls_branch), .cls_shift(cls_shift),
        .cls_io(cls_io), .mem_src(mem_src), .mem_dst(mem_dst),
        .br_kind(br_kind), .br_flag_sel(br_flag_sel),
        .br_on_true(br_on_true), .br_always(br_always)
    );

    // bit layout: valid22 group21:20 dst19:17 src16:14 halt13
    // load12 alu11 branch10 shift9 io8 msrc7 mdst6 kind5:4 fsel3:2 true1 always0
    wire [22:0] act = {dec_valid, dec_group, dec_dst, dec_src, dec_halt,
                       cls_load, cls_alu, cls_branch, cls_shift, cls_io,
                       mem_src, mem_dst, br_kind, br_flag_sel, br_on_true, br_always};

    function automatic logic [22:0] ref_dec(input logic [7:0] o);
        logic       h, ld, al, br, sh, io, ms, md;
        logic [1:0] k;
        logic [5:0] brf;
        h = (o == 8'h00) || (o == 8'h01) || (o == 8'hFF);
        {ld, al, br, sh, io, ms, md} = '0;
        k = 2'd0;
        if (!h) begin
            case (o[7:6])
                2'b11: begin ld = 1; ms = (o[2:0] == 7); md = (o[5:3] == 7); end
                2'b10: begin al = 1; ms = (o[2:0] == 7); end
                2'b01: if (o[0]) io = 1; else begin br = 1; k = o[1] ? 2'd1 : 2'd0; end
                default: case (o[2:0])
                    3'd2: sh = 1;
                    3'd3, 3'd7: begin br = 1; k = 2'd2; end
                    3'd5: begin br = 1; k = 2'd3; end
                    3'd6: begin ld = 1; md = (o[5:3] == 7); end
                    default: al = 1;
                endcase
            endcase
        end
        brf = br ? {k, o[4:3], o[5], o[2]} : 6'd0;
        return {1'b1, o, h, ld, al, br, sh, io, ms, md, brf};
    endfunction

    task automatic chk(input string tag, input logic [22:0] a, input logic [22:0] e);
        compared++;
        if (a !== e) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, a, e);
        end
    endtask

    task automatic check_item(input logic [7:0] o, input logic [22:0] e);
        string ctag;
        logic [4:0] c_act;
        if (e[13]) ctag = "R4";
        else case (o[7:6])
            2'b11: ctag = "R6";
            2'b10: ctag = "R7";
            2'b01: ctag = "R8";
            default: ctag = "R9";
        endcase
        chk("R3 fields/R2 valid", {14'd0, act[22:14]}, {14'd0, e[22:14]});
        chk(ctag, {17'd0, act[13:8]}, {17'd0, e[13:8]});
        c_act = act[12:8];
        // R5: exactly one class strobe for non-halt opcodes
        chk("R5", 23'($countones(c_act)), e[13] ? 23'd0 : 23'd1);
        chk("R11", {21'd0, act[7:6]}, {21'd0, e[7:6]});
        chk("R10", {17'd0, act[5:0]}, {17'd0, e[5:0]});
    endtask

    task automatic load_op(input logic [7:0] o);
        @(negedge clk);
        ir_byte = o;
        ir_load = 1'b1;
        q_op.push_back(o);
        q_exp.push_back(ref_dec(o));
    endtask

    task automatic idle(input int n, input logic [7:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ir_load = 1'b0;
            ir_byte = junk + 8'(i);
        end
    endtask

    // monitor: pops one expected item for each captured load
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && ir_load) begin
                @(negedge clk);
                if (q_exp.size() == 0) begin
                    mismatched++;
                    $display("FAIL R2: load with empty scoreboard");
                end else begin
                    check_item(q_op.pop_front(), q_exp.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [22:0] held;
        repeat (3) @(negedge clk);
        chk("R1 in reset", act, 23'd0);
        ir_byte = 8'hC1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 before first load", act, 23'd0);

        // full sweep of every opcode, back to back
        for (int i = 0; i < 256; i++) load_op(8'(i));

        // hold: byte changes to halt codes without the strobe
        load_op(8'h46);
        held = ref_dec(8'h46);
        idle(1, 8'hFF);
        idle(3, 8'hFF);
        @(negedge clk);
        chk("R2 hold", act, held);

        // halt neighbours and override
        load_op(8'hFE);
        load_op(8'hFF);
        load_op(8'h02);
        load_op(8'h00);
        load_op(8'h01);
        load_op(8'hC7);
        idle(1, 8'h00);
        idle(3, 8'h3C);
        @(negedge clk);
        chk("R2 hold after halt code", act, ref_dec(8'hC7));

        if (q_exp.size() != 0) begin
            mismatched++;
            $display("FAIL R2: actual %0d pending expected 0", q_exp.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule